// File: doc/BRIEF.md
# Comparator Timer Channel

This block is a single match channel of an event timer. An external free-running 64-bit counter value is presented on every clock. The channel holds a programmable comparator and, when the counter has reached or passed it, emits a one-cycle fire pulse. The channel is written as two 32-bit halves. Writes go either to the comparator or, in periodic mode, to a period register.

In one-shot mode the channel fires once per programming. In periodic mode it moves the comparator forward by the period after every fire. If the counter has jumped far ahead, it keeps adding the period until the comparator is again in front of the counter value captured at the fire. A narrow (32-bit) mode keeps only the low halves of the comparator and the period, and compares with 32-bit signed arithmetic. A one-shot narrow channel also fires when the low half of the counter wraps.

Top module: `ctch_channel`

## Requirements
- R1: After reset `fire_o` is 0 and `cmp_o` reads all ones.
- R2: In one-shot mode, writing a comparator half (`cmp_wr_lo_i` writes bits 31:0, `cmp_wr_hi_i` writes bits 63:32) arms the channel. The channel then fires exactly once, at the first sampled counter value that equals or is past the comparator. It stays quiet until the comparator is written again.
- R3: No match fire happens while `chan_en_i` or `run_i` is low. A channel whose match is pending fires once both are high again.
- R4: In periodic mode with the set-value flag clear, a comparator-half write changes only the period; `cmp_o` keeps its value.
- R5: A pulse on `setval_set_i` sets the set-value flag. A periodic write made while the flag is set updates both the comparator half and the period half. Any comparator-half write clears the flag.
- R6: Periodic period writes drop the top bit of the period: bit 31 of the low half in narrow mode, and bit 31 of the high half (counter bit 63) in wide mode.
- R7: While `narrow_i` is high, bits 63:32 of the comparator and the period read as zero from the following cycle on. High-half writes leave them at zero.
- R8: A periodic fire with a nonzero period adds the period to the comparator once per cycle. This continues until the comparator is ahead of the counter value sampled at the fire, and no further fire occurs meanwhile. In narrow mode each sum is truncated to 32 bits.
- R9: "Reached or passed" means the signed difference comparator minus counter is at most zero. This difference is 32-bit over the low halves in narrow mode and 64-bit otherwise.
- R10: An armed one-shot narrow channel fires once more when bit 31 of the counter falls from 1 to 0 (the low half wrapping from 0xFFFFFFFF to 0). A rewrite of the comparator re-enables this wrap fire. Periodic and wide channels give no wrap fire.
- R11: `fire_o` is a registered pulse. It goes high in the cycle after the clock edge that sampled the firing condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Main counter value |
| run_i | input | 1 | Main counter running |
| chan_en_i | input | 1 | Channel enable |
| periodic_i | input | 1 | 1 = periodic, 0 = one-shot |
| narrow_i | input | 1 | 1 = 32-bit mode |
| setval_set_i | input | 1 | Pulse that sets the set-value flag |
| cmp_wr_lo_i | input | 1 | Write strobe for bits 31:0 |
| cmp_wr_hi_i | input | 1 | Write strobe for bits 63:32 |
| wr_data_i | input | 32 | Write data for the selected half |
| fire_o | output | 1 | One-cycle fire pulse |
| cmp_o | output | 64 | Comparator readback |

## Verification
The hardest situation to reach is the periodic catch-up. It needs a channel that is running and armed while the counter lands far beyond the comparator in a single step. Plain counting never gets there, so the stimulus loads the counter with a jump several periods ahead. It then checks that exactly one pulse appears and that the comparator settles on the first multiple past the jump. The low-half wrap needs the same treatment: the counter is preloaded a few ticks below 0xFFFFFFFF. A random phase mixes jumps, writes and mode changes and compares every cycle against a bench model.

// File: rtl/ctch_pkg.sv
package ctch_pkg;
  localparam int unsigned CT_W = 64;
  localparam int unsigned CT_H = CT_W / 2;

  typedef logic [CT_W-1:0] word_t;
  typedef logic [CT_H-1:0] half_t;

  // target reached or passed by rv, using signed difference of the active width
  function automatic logic at_or_past(word_t tgt, word_t rv, logic nar);
    word_t dw;
    half_t dh;
    dw = tgt - rv;
    dh = tgt[CT_H-1:0] - rv[CT_H-1:0];
    if (nar) return $signed(dh) <= 0;
    return $signed(dw) <= 0;
  endfunction

  function automatic word_t advance(word_t c, word_t p, logic nar);
    word_t s;
    s = c + p;
    if (nar) s[CT_W-1:CT_H] = '0;
    return s;
  endfunction

  function automatic half_t clip_top(half_t d);
    return {1'b0, d[CT_H-2:0]};
  endfunction

  function automatic half_t period_lo(half_t d, logic nar);
    return nar ? clip_top(d) : d;
  endfunction
endpackage

// File: rtl/ctch_cmp_unit.sv
module ctch_cmp_unit
  import ctch_pkg::*;
(
  input  word_t tgt_i,
  input  word_t rv_i,
  input  logic  narrow_i,
  output logic  past_o
);
  assign past_o = at_or_past(tgt_i, rv_i, narrow_i);
endmodule

// File: rtl/ctch_wrap_det.sv
module ctch_wrap_det
  import ctch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic msb_i,
  output logic wrap_o
);
  logic msb_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msb_q <= 1'b0;
    else        msb_q <= msb_i;
  end
  assign wrap_o = msb_q & ~msb_i;
endmodule

// File: rtl/ctch_regs.sv
module ctch_regs
  import ctch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  narrow_i,
  input  logic  periodic_i,
  input  logic  setval_set_i,
  input  logic  wr_lo_i,
  input  logic  wr_hi_i,
  input  half_t wdata_i,
  input  logic  step_i,
  output word_t cmp_q,
  output word_t period_q,
  output logic  setval_q
);
  word_t cmp_n, per_n;
  logic  sv_n;

  always_comb begin
    cmp_n = cmp_q;
    per_n = period_q;
    sv_n  = setval_q;
    if (wr_lo_i || wr_hi_i) begin
      if (!periodic_i || setval_q) begin
        if (wr_lo_i) cmp_n[CT_H-1:0]    = wdata_i;
        if (wr_hi_i) cmp_n[CT_W-1:CT_H] = wdata_i;
      end
      if (periodic_i) begin
        if (wr_lo_i) per_n[CT_H-1:0]    = period_lo(wdata_i, narrow_i);
        if (wr_hi_i) per_n[CT_W-1:CT_H] = clip_top(wdata_i);
      end
      sv_n = 1'b0;
    end else if (step_i) begin
      cmp_n = advance(cmp_q, period_q, narrow_i);
    end
    if (setval_set_i) sv_n = 1'b1;
    if (narrow_i) begin
      cmp_n[CT_W-1:CT_H] = '0;
      per_n[CT_W-1:CT_H] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q    <= '1;
      period_q <= '0;
      setval_q <= 1'b0;
    end else begin
      cmp_q    <= cmp_n;
      period_q <= per_n;
      setval_q <= sv_n;
    end
  end
endmodule

// File: rtl/ctch_channel.sv
module ctch_channel
  import ctch_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] cnt_i,
  input  logic        run_i,
  input  logic        chan_en_i,
  input  logic        periodic_i,
  input  logic        narrow_i,
  input  logic        setval_set_i,
  input  logic        cmp_wr_lo_i,
  input  logic        cmp_wr_hi_i,
  input  logic [31:0] wr_data_i,
  output logic        fire_o,
  output logic [63:0] cmp_o
);
  word_t cmp_q, period_q, snap_q;
  logic  setval_q, armed_q, catch_q, wrap_taken_q, fire_q;
  logic  past_cnt, past_snap, wrap_seen;
  logic  wr, active, per_nz, reload, keep_step, do_step;
  logic  match_evt, wrap_evt;

  ctch_regs u_regs (
    .clk(clk), .rst_n(rst_n), .narrow_i(narrow_i), .periodic_i(periodic_i),
    .setval_set_i(setval_set_i), .wr_lo_i(cmp_wr_lo_i), .wr_hi_i(cmp_wr_hi_i),
    .wdata_i(wr_data_i), .step_i(do_step), .cmp_q(cmp_q), .period_q(period_q),
    .setval_q(setval_q)
  );

  // counter against comparator, and comparator against the snapshot taken at fire
  ctch_cmp_unit u_cmp_cnt (.tgt_i(cmp_q), .rv_i(cnt_i),  .narrow_i(narrow_i), .past_o(past_cnt));
  ctch_cmp_unit u_cmp_snp (.tgt_i(cmp_q), .rv_i(snap_q), .narrow_i(narrow_i), .past_o(past_snap));

  ctch_wrap_det u_wrap (.clk(clk), .rst_n(rst_n), .msb_i(cnt_i[CT_H-1]), .wrap_o(wrap_seen));

  assign wr        = cmp_wr_lo_i | cmp_wr_hi_i;
  assign active    = chan_en_i & run_i;
  assign per_nz    = |period_q;
  assign reload    = periodic_i & per_nz;
  assign keep_step = past_snap & per_nz;
  assign match_evt = active & armed_q & ~catch_q & past_cnt;
  assign wrap_evt  = active & ~periodic_i & narrow_i & armed_q & ~wrap_taken_q & wrap_seen;
  assign do_step   = ~wr & ((match_evt & reload) | (catch_q & keep_step));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q      <= 1'b0;
      catch_q      <= 1'b0;
      snap_q       <= '0;
      wrap_taken_q <= 1'b0;
      fire_q       <= 1'b0;
    end else begin
      fire_q <= match_evt | wrap_evt;
      if (wr) begin
        armed_q      <= 1'b1;
        catch_q      <= 1'b0;
        wrap_taken_q <= 1'b0;
      end else begin
        if (match_evt) begin
          if (reload) begin
            catch_q <= 1'b1;
            snap_q  <= cnt_i;
          end else begin
            armed_q <= 1'b0;
          end
        end else if (catch_q && !keep_step) begin
          catch_q <= 1'b0;
        end
        if (wrap_evt) wrap_taken_q <= 1'b1;
      end
    end
  end

  assign fire_o = fire_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/ctch_channel_chk.sv
module ctch_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_i,
  input logic        chan_en_i,
  input logic        periodic_i,
  input logic        narrow_i,
  input logic        setval_set_i,
  input logic        cmp_wr_lo_i,
  input logic        cmp_wr_hi_i,
  input logic        fire_o,
  input logic [63:0] cmp_o,
  input logic        setval_q,
  input logic        armed_q,
  input logic        match_evt,
  input logic        period_top
);
  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(chan_en_i && run_i));

  assert_oneshot_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !periodic_i && !cmp_wr_lo_i && !cmp_wr_hi_i) |=> !armed_q);

  assert_setval_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_wr_lo_i || cmp_wr_hi_i) && !setval_set_i) |=> !setval_q);

  assert_keep_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_lo_i && periodic_i && !setval_q && !narrow_i) |=> (cmp_o == $past(cmp_o)));

  assert_upper_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(narrow_i && rst_n) |-> (cmp_o[63:32] == 32'h0));

  assert_period_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && periodic_i && cmp_wr_hi_i) |-> !period_top);
endmodule

bind ctch_channel ctch_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .chan_en_i(chan_en_i),
  .periodic_i(periodic_i), .narrow_i(narrow_i), .setval_set_i(setval_set_i),
  .cmp_wr_lo_i(cmp_wr_lo_i), .cmp_wr_hi_i(cmp_wr_hi_i), .fire_o(fire_o),
  .cmp_o(cmp_o), .setval_q(setval_q), .armed_q(armed_q), .match_evt(match_evt),
  .period_top(period_q[63])
);

// File: tb/sim_ctch_channel.sv
module sim_ctch_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = 64'h0;
  logic        run = 1'b0, en = 1'b0, per = 1'b0, nar = 1'b0;
  logic        svs = 1'b0, wlo = 1'b0, whi = 1'b0;
  logic [31:0] wd = 32'h0;
  logic        fire_o;
  logic [63:0] cmp_o;

  int total = 0, bad = 0, fires = 0;
  bit done = 1'b0;
  logic        last_fire;
  logic [63:0] last_cnt, fire_cnt;

  always #4 clk = ~clk;

  ctch_channel u0 (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .run_i(run), .chan_en_i(en),
    .periodic_i(per), .narrow_i(nar), .setval_set_i(svs), .cmp_wr_lo_i(wlo),
    .cmp_wr_hi_i(whi), .wr_data_i(wd), .fire_o(fire_o), .cmp_o(cmp_o)
  );

  // ---------- bench arithmetic, restated ----------
  function automatic bit b_reached(logic [63:0] c, logic [63:0] v, bit n);
    logic [63:0] d;
    logic [31:0] h;
    d = c - v;
    h = c[31:0] - v[31:0];
    if (n) return (h == 32'h0) || h[31];
    return (d == 64'h0) || d[63];
  endfunction

  function automatic logic [63:0] b_add(logic [63:0] c, logic [63:0] p, bit n);
    logic [63:0] s;
    s = c + p;
    return n ? {32'h0, s[31:0]} : s;
  endfunction

  // ---------- bench model ----------
  logic [63:0] m_cmp, m_per, m_snap;
  logic m_sv, m_arm, m_cat, m_wt, m_msb, m_fire;

  always @(posedge clk or negedge rst_n) begin
    logic wr, act, hit, wrp;
    logic [63:0] nc, np, ns;
    logic nsv, narm, ncat, nwt;
    if (!rst_n) begin
      m_cmp <= '1; m_per <= '0; m_snap <= '0; m_sv <= 0; m_arm <= 0;
      m_cat <= 0; m_wt <= 0; m_msb <= 0; m_fire <= 0;
    end else begin
      wr  = wlo | whi;
      act = en & run;
      hit = act & m_arm & ~m_cat & b_reached(m_cmp, cnt, nar);
      wrp = act & ~per & nar & m_arm & ~m_wt & m_msb & ~cnt[31];
      nc = m_cmp; np = m_per; ns = m_snap;
      nsv = m_sv; narm = m_arm; ncat = m_cat; nwt = m_wt;
      if (wr) begin
        if (!per || m_sv) begin
          if (wlo) nc[31:0] = wd;
          if (whi) nc[63:32] = wd;
        end
        if (per) begin
          if (wlo) np[31:0] = nar ? (wd & 32'h7fffffff) : wd;
          if (whi) np[63:32] = wd & 32'h7fffffff;
        end
        nsv = 0; narm = 1; ncat = 0; nwt = 0;
      end else begin
        if (hit) begin
          if (per && m_per != 0) begin
            nc = b_add(m_cmp, m_per, nar); ncat = 1; ns = cnt;
          end else narm = 0;
        end else if (m_cat) begin
          if (m_per != 0 && b_reached(m_cmp, m_snap, nar)) nc = b_add(m_cmp, m_per, nar);
          else ncat = 0;
        end
        if (wrp) nwt = 1;
      end
      if (svs) nsv = 1;
      if (nar) begin nc[63:32] = 0; np[63:32] = 0; end
      m_cmp <= nc; m_per <= np; m_snap <= ns; m_sv <= nsv; m_arm <= narm;
      m_cat <= ncat; m_wt <= nwt; m_msb <= cnt[31]; m_fire <= hit | wrp;
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: compare at the falling edge, then advance the counter and drop pulses
  task automatic step();
    @(negedge clk);
    chk(fire_o === m_fire, "R11 fire vs model", {63'h0, fire_o}, {63'h0, m_fire});
    chk(cmp_o === m_cmp, "R8 cmp vs model", cmp_o, m_cmp);
    last_fire = fire_o;
    last_cnt  = cnt;
    if (fire_o) begin fires++; fire_cnt = cnt; end
    if (run) cnt = cnt + 64'h1;
    wlo = 0; whi = 0; svs = 0;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_lo(logic [31:0] d); wd = d; wlo = 1; step(); endtask
  task automatic wr_hi(logic [31:0] d); wd = d; whi = 1; step(); endtask
  task automatic set_sv(); svs = 1; step(); endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(fire_o == 1'b0, "R1 fire after reset", {63'h0, fire_o}, 64'h0);
    chk(cmp_o == '1, "R1 cmp after reset", cmp_o, '1);

    // R2 / R11: one-shot wide, single fire at 0x120
    cnt = 64'h100; run = 1; en = 1;
    wr_hi(32'h0);
    wr_lo(32'h120);
    chk(cmp_o == 64'h120, "R2 cmp written", cmp_o, 64'h120);
    fires = 0;
    while (cnt < 64'h130) step();
    chk(fires == 1, "R2 single fire", fires, 1);
    chk(fire_cnt == 64'h120, "R11 fire timing", fire_cnt, 64'h120);

    // R3: disabled channel does not fire, fires once enabled
    en = 0;
    wr_lo(32'h140);
    fires = 0;
    while (cnt < 64'h150) step();
    chk(fires == 0, "R3 no fire while disabled", fires, 0);
    en = 1; fires = 0;
    steps(4);
    chk(fires == 1, "R3 fire after enable", fires, 1);
    // R3: stopped counter
    run = 0;
    wr_lo(32'h150);
    fires = 0;
    steps(5);
    chk(fires == 0, "R3 no fire while stopped", fires, 0);
    run = 1;
    steps(3);
    chk(fires == 1, "R3 fire after restart", fires, 1);

    // R4 / R5: periodic writes
    per = 1;
    set_sv();
    wr_lo(32'h200);
    chk(cmp_o == 64'h200, "R5 setval write updates cmp", cmp_o, 64'h200);
    wr_lo(32'h40);
    chk(cmp_o == 64'h200, "R4 period-only write keeps cmp", cmp_o, 64'h200);
    fires = 0;
    while (cnt < 64'h250) step();
    chk(fires == 2, "R8 periodic fires", fires, 2);
    chk(cmp_o == 64'h280, "R8 reload by period", cmp_o, 64'h280);
    // R8: catch-up after a jump
    cnt = 64'h3f0; fires = 0;
    steps(10);
    chk(fires == 1, "R8 one fire during catch-up", fires, 1);
    chk(cmp_o == 64'h400, "R8 catch-up result", cmp_o, 64'h400);

    // R6 / R8: narrow period mask and truncated reload
    en = 0; nar = 1;
    step();
    cnt = 64'h5_ffff_ffe0;
    set_sv();
    en = 1;
    wr_lo(32'hffff_fff0);
    fires = 0;
    steps(32);
    chk(fires == 1, "R10 no wrap fire when periodic", fires, 1);
    chk(cmp_o == 64'h7fff_ffe0, "R6 masked period, R8 truncated sum", cmp_o, 64'h7fff_ffe0);

    // R7: narrow clears upper half
    en = 0; nar = 0; per = 0;
    step();
    wr_hi(32'h1234_5678);
    chk(cmp_o[63:32] == 32'h1234_5678, "R7 wide hi write", {32'h0, cmp_o[63:32]}, 64'h1234_5678);
    nar = 1;
    step();
    chk(cmp_o[63:32] == 32'h0, "R7 upper cleared", {32'h0, cmp_o[63:32]}, 64'h0);
    wr_hi(32'habcd);
    chk(cmp_o[63:32] == 32'h0, "R7 hi write ignored", {32'h0, cmp_o[63:32]}, 64'h0);

    // R9: signed comparison width
    en = 1; cnt = 64'h10;
    wr_lo(32'h9000_0010);
    fires = 0;
    steps(3);
    chk(fires == 1, "R9 narrow signed passed", fires, 1);
    nar = 0; cnt = 64'h10;
    wr_lo(32'h9000_0010);
    fires = 0;
    steps(5);
    chk(fires == 0, "R9 wide not passed", fires, 0);

    // R10: wrap fire in one-shot narrow
    nar = 1; cnt = 64'h1_ffff_fff8;
    wr_lo(32'h100);
    fires = 0; fire_cnt = '1;
    while (cnt[31:0] != 32'h0) step();
    while (cnt[31:0] < 32'h3) step();
    chk(fires == 1, "R10 wrap fire", fires, 1);
    chk(fire_cnt[31:0] == 32'h0, "R10 wrap fire timing", {32'h0, fire_cnt[31:0]}, 64'h0);
    while (cnt[31:0] < 32'h110) step();
    chk(fires == 2, "R10 match after wrap", fires, 2);
    nar = 0; cnt = 64'h1_ffff_fff8;
    wr_hi(32'h2);
    fires = 0;
    steps(16);
    chk(fires == 0, "R10 no wrap fire in wide mode", fires, 0);

    // mixed random phase against the model
    for (int i = 0; i < 4000; i++) begin
      en  = ($urandom % 8) != 0;
      run = ($urandom % 8) != 0;
      if ($urandom % 64 == 0) per = ~per;
      if ($urandom % 96 == 0) nar = ~nar;
      if ($urandom % 128 == 0) cnt = cnt + ($urandom % 256);
      if ($urandom % 200 == 0) cnt = {cnt[63:32], 32'hffff_fff0};
      svs = ($urandom % 16) == 0;
      wd  = ($urandom % 4 == 0) ? $urandom : (cnt[31:0] + ($urandom % 64));
      wlo = ($urandom % 10) == 0;
      whi = ($urandom % 40) == 0;
      if (whi) wd = ($urandom % 2) ? cnt[63:32] : 32'h0;
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule